// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block watches sixteen general-purpose input pins and raises one interrupt line per pin toward a downstream interrupt controller. Each pin has its own 3-bit trigger style, chosen by software: high level, low level, rising edge, falling edge, or any transition. The remaining three codes switch detection off for that pin. Every pin input first passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with the value one cycle earlier.

Software reaches the block through a small register port. The write is synchronous and the read is combinational. Two style words hold the per-pin fields: address 0 holds pins 0 to 7 and address 1 holds pins 8 to 15. Address 2 is the pending-event word, and software clears a bit there by writing 1 to it. An edge event stays pending until software clears it. A level event cannot be cleared while its pin still sits at the active level. The interrupt vector is the pending word itself.

Top module: `gpio_style_det`

## Requirements
- R1: After reset, both style words and the pending word read as zero, and the interrupt vector is zero.
- R2: The style field of pin p sits in word p/8 (address 0 or 1) at bits [3*(p%8)+2 : 3*(p%8)]. Bits 31:24 of a style word read as 0. Writing one style word leaves the other unchanged. Reads of address 3 return 0.
- R3: The style codes are 0 for high level, 1 for low level, 2 for rising, 3 for falling and 4 for any transition. A pin with code 5, 6 or 7 never sets its pending bit.
- R4: Under the rising style, a low-to-high change of the pin sets its pending bit, and a high-to-low change sets nothing.
- R5: Under the falling style, a high-to-low change sets the pending bit, and a low-to-high change sets nothing.
- R6: Under the any-transition style, both directions of change set the pending bit.
- R7: A pending bit falls only when the pending word (address 2) is written with a 1 in that bit. Writing 0 to a bit leaves it unchanged, and an edge event stays pending until such a write.
- R8: Under a level style, a write of 1 does not clear the pending bit while the synchronized pin is still at its active level. Once the level has gone away, a write of 1 clears the bit.
- R9: The interrupt vector equals the pending word. Reading address 2 returns the pending bits in bits 15:0 and 0 in bits 31:16.
- R10: A pin change driven between clock edges shows on the interrupt vector after the third rising edge that follows it, and not before.
- R11: Changing a pin's style while the pin is stable does not by itself set the pin's pending bit under any edge style.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 16 | Raw pin levels, asynchronous to clk |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 and 1 are the style words, 2 is the pending word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_out | output | 16 | Per-pin interrupt lines, equal to the pending bits |

## Verification
The hardest case to reach is a clear that arrives while a level condition is still present. A pending bit sitting in that state looks the same at the ports as an ordinary latched event. The bench therefore holds a pin at its active level, writes 1 to its bit, and reads the bit back before releasing the pin. It then releases the pin and clears again, which shows the bit was held by the level and was not stuck. The bench also probes the synchronizer latency cycle by cycle after a single edge, and it reprograms styles on a stable pin to show that a style change alone creates no event.

// File: rtl/gpio_sty_pkg.sv
package gpio_sty_pkg;
   localparam int STY_W = 3;

   localparam logic [STY_W-1:0] STY_LVL_HI = 3'd0;
   localparam logic [STY_W-1:0] STY_LVL_LO = 3'd1;
   localparam logic [STY_W-1:0] STY_RISE   = 3'd2;
   localparam logic [STY_W-1:0] STY_FALL   = 3'd3;
   localparam logic [STY_W-1:0] STY_ANY    = 3'd4;
   localparam logic [STY_W-1:0] STY_MAX_ON = 3'd4;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_style_regs.sv
module gpio_style_regs
   import gpio_sty_pkg::*;
#(
   parameter int NUM_PINS     = 16,
   parameter int PINS_PER_REG = 8,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 2,
   localparam int NUM_CFG     = NUM_PINS / PINS_PER_REG,
   localparam int FLD_BITS    = PINS_PER_REG * STY_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [FLD_BITS-1:0]       wdata,
   output logic [NUM_CFG*FLD_BITS-1:0] cfg_flat,
   output logic [NUM_PINS*STY_W-1:0] style_flat
);
   for (genvar r = 0; r < NUM_CFG; r++) begin : g_word
      logic [FLD_BITS-1:0] word_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_en && (addr == ADDR_W'(r)))
            word_q <= wdata;
      end

      assign cfg_flat[r*FLD_BITS +: FLD_BITS] = word_q;

      for (genvar k = 0; k < PINS_PER_REG; k++) begin : g_fld
         assign style_flat[(r*PINS_PER_REG + k)*STY_W +: STY_W] =
            word_q[k*STY_W +: STY_W];
      end
   end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
   import gpio_sty_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level,
   input  logic [STY_W-1:0] style,
   input  logic             clr,
   output logic             pend
);
   logic prev_q;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   always_comb begin
      case (style)
         STY_LVL_HI: hit = level;
         STY_LVL_LO: hit = ~level;
         STY_RISE:   hit = level & ~prev_q;
         STY_FALL:   hit = ~level & prev_q;
         STY_ANY:    hit = level ^ prev_q;
         default:    hit = 1'b0;
      endcase
   end

   // A fresh hit wins over a same-cycle clear: no edge is lost and a
   // level that is still present keeps the bit set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= (pend & ~clr) | hit;
   end
endmodule

// File: rtl/gpio_style_det.sv
module gpio_style_det
   import gpio_sty_pkg::*;
#(
   parameter int NUM_PINS     = 16,
   parameter int PINS_PER_REG = 8,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic [NUM_PINS-1:0] irq_out
);
   localparam int NUM_CFG     = NUM_PINS / PINS_PER_REG;
   localparam int FLD_BITS    = PINS_PER_REG * STY_W;
   localparam int STATUS_ADDR = NUM_CFG;

   if (NUM_PINS % PINS_PER_REG != 0) begin : g_chk_split
      $error("NUM_PINS must be a multiple of PINS_PER_REG");
   end
   if (FLD_BITS > DATA_W) begin : g_chk_fld
      $error("style fields do not fit in one data word");
   end
   if (NUM_PINS > DATA_W) begin : g_chk_pins
      $error("pending word wider than the data bus");
   end
   if (STATUS_ADDR >= (1 << ADDR_W)) begin : g_chk_addr
      $error("address space too small for the register set");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("synchronizer needs at least two stages");
   end

   logic [NUM_PINS-1:0]         sync_q;
   logic [NUM_PINS*STY_W-1:0]   style_flat;
   logic [NUM_CFG*FLD_BITS-1:0] cfg_flat;
   logic [NUM_PINS-1:0]         clr_vec;
   logic [NUM_PINS-1:0]         pend_vec;
   logic                        status_wr;

   gpio_pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   gpio_style_regs #(
      .NUM_PINS     (NUM_PINS),
      .PINS_PER_REG (PINS_PER_REG),
      .DATA_W       (DATA_W),
      .ADDR_W       (ADDR_W)
   ) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata[FLD_BITS-1:0]),
      .cfg_flat   (cfg_flat),
      .style_flat (style_flat)
   );

   assign status_wr = reg_wr && (reg_addr == ADDR_W'(STATUS_ADDR));
   assign clr_vec   = status_wr ? reg_wdata[NUM_PINS-1:0] : '0;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_pin_detect det_i (
         .clk   (clk),
         .rst_n (rst_n),
         .level (sync_q[p]),
         .style (style_flat[p*STY_W +: STY_W]),
         .clr   (clr_vec[p]),
         .pend  (pend_vec[p])
      );
   end

   assign irq_out = pend_vec;

   always_comb begin
      reg_rdata = '0;
      for (int r = 0; r < NUM_CFG; r++) begin
         if (reg_addr == ADDR_W'(r))
            reg_rdata[FLD_BITS-1:0] = cfg_flat[r*FLD_BITS +: FLD_BITS];
      end
      if (reg_addr == ADDR_W'(STATUS_ADDR))
         reg_rdata[NUM_PINS-1:0] = pend_vec;
   end

   if (FLD_BITS < DATA_W) begin : g_hi_bits
      logic wdata_hi_unused;
      assign wdata_hi_unused = ^reg_wdata[DATA_W-1:FLD_BITS];
   end
endmodule

// File: rtl/gpio_style_det_chk.sv
module gpio_style_det_chk
   import gpio_sty_pkg::*;
#(
   parameter int NUM_PINS     = 16,
   parameter int PINS_PER_REG = 8,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_wr,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic [DATA_W-1:0]         reg_wdata,
   input logic [DATA_W-1:0]         reg_rdata,
   input logic [NUM_PINS-1:0]       irq_out,
   input logic [NUM_PINS*STY_W-1:0] style_flat,
   input logic [NUM_PINS-1:0]       sync_q
);
   localparam int NUM_CFG     = NUM_PINS / PINS_PER_REG;
   localparam int FLD_BITS    = PINS_PER_REG * STY_W;
   localparam int STATUS_ADDR = NUM_CFG;
   localparam logic [DATA_W-1:0] FLD_MASK = DATA_W'((64'd1 << FLD_BITS) - 64'd1);

   assert_irq_on_status_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(STATUS_ADDR)) |->
         (reg_rdata == DATA_W'(irq_out)));

   for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
      assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(reg_wr && (reg_addr == ADDR_W'(r))) && (reg_addr == ADDR_W'(r))) |->
            (reg_rdata == ($past(reg_wdata) & FLD_MASK)));
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      assert_drop_needs_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_out[i]) |->
            $past(reg_wr && (reg_addr == ADDR_W'(STATUS_ADDR)) && reg_wdata[i]));

      assert_disabled_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_out[i]) |-> ($past(style_flat[i*STY_W +: STY_W]) <= STY_MAX_ON));

      assert_level_holds_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(reg_wr && (reg_addr == ADDR_W'(STATUS_ADDR)) && reg_wdata[i]) &&
          $past(style_flat[i*STY_W +: STY_W] == STY_LVL_HI) && $past(sync_q[i])) |->
            irq_out[i]);
   end
endmodule

bind gpio_style_det gpio_style_det_chk #(
   .NUM_PINS     (NUM_PINS),
   .PINS_PER_REG (PINS_PER_REG),
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .irq_out    (irq_out),
   .style_flat (style_flat),
   .sync_q     (sync_q)
);

// File: tb/gpio_style_det_tb_top.sv
`timescale 1ns/1ps
module gpio_style_det_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pins = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] irq_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [31:0] shadow [2];

   always #5 clk = ~clk;

   gpio_style_det dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pins),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_style(int p, logic [2:0] s);
      shadow[p/8][(p%8)*3 +: 3] = s;
      wr(2'(p/8), shadow[p/8]);
   endtask

   task automatic set_pin(int p, logic v);
      @(negedge clk);
      pins[p] = v;
   endtask

   task automatic clean();
      @(negedge clk);
      pins = '0;
      cyc(4);
      shadow[0] = '0; shadow[1] = '0;
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      cyc(4);
      wr(2'd2, 32'h0000_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(2'd0, d); chk("R1", "style word 0", d, 32'h0);
      rd(2'd1, d); chk("R1", "style word 1", d, 32'h0);
      rd(2'd2, d); chk("R1", "pending word", d, 32'h0);
      chk("R1", "irq vector", 32'(irq_out), 32'h0);
   endtask

   task automatic t_style_rw();
      logic [31:0] d;
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); chk("R2", "word 0 upper bits zero", d, 32'h00FF_FFFF);
      wr(2'd1, 32'h0000_0123);
      rd(2'd1, d); chk("R2", "word 1 readback", d, 32'h0000_0123);
      rd(2'd0, d); chk("R2", "word 0 unchanged", d, 32'h00FF_FFFF);
      rd(2'd3, d); chk("R2", "address 3 reads zero", d, 32'h0);
      clean();
      // pin 12 style 2 lands in word 1 at bits 14:12
      set_style(12, 3'd2);
      rd(2'd1, d); chk("R2", "pin 12 field position", d, 32'h0000_2000);
      clean();
   endtask

   task automatic t_rise();
      logic [31:0] d;
      set_style(2, 3'd2);
      set_pin(2, 1'b1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R10", "not visible after two edges", 32'(irq_out[2]), 32'h0);
      cyc(1);
      chk("R10", "visible after third edge", 32'(irq_out[2]), 32'h1);
      rd(2'd2, d); chk("R9", "pending word mirrors irq", d, 32'h0000_0004);
      set_pin(2, 1'b0);
      cyc(4);
      wr(2'd2, 32'h0000_FFFB);
      chk("R7", "write 0 keeps edge pending", 32'(irq_out[2]), 32'h1);
      wr(2'd2, 32'h0000_0004);
      chk("R7", "write 1 clears edge", 32'(irq_out[2]), 32'h0);
      set_pin(2, 1'b1);
      cyc(4);
      wr(2'd2, 32'h0000_0004);
      set_pin(2, 1'b0);
      cyc(4);
      chk("R4", "falling change ignored", 32'(irq_out[2]), 32'h0);
      clean();
   endtask

   task automatic t_fall();
      set_style(9, 3'd3);
      set_pin(9, 1'b1);
      cyc(4);
      chk("R5", "rising change ignored", 32'(irq_out), 32'h0);
      set_pin(9, 1'b0);
      cyc(4);
      chk("R5", "falling change sets", 32'(irq_out), 32'h0000_0200);
      clean();
   endtask

   task automatic t_any();
      set_style(13, 3'd4);
      set_pin(13, 1'b1);
      cyc(4);
      chk("R6", "rise sets", 32'(irq_out), 32'h0000_2000);
      wr(2'd2, 32'h0000_2000);
      chk("R6", "cleared between edges", 32'(irq_out), 32'h0);
      set_pin(13, 1'b0);
      cyc(4);
      chk("R6", "fall sets", 32'(irq_out), 32'h0000_2000);
      clean();
   endtask

   task automatic t_level_high();
      logic [31:0] d;
      set_style(5, 3'd0);
      set_pin(5, 1'b1);
      cyc(4);
      chk("R8", "high level sets", 32'(irq_out), 32'h0000_0020);
      wr(2'd2, 32'h0000_0020);
      rd(2'd2, d); chk("R8", "clear refused while high", d, 32'h0000_0020);
      set_pin(5, 1'b0);
      cyc(4);
      chk("R8", "stays latched after release", 32'(irq_out), 32'h0000_0020);
      wr(2'd2, 32'h0000_0020);
      chk("R8", "clear accepted after release", 32'(irq_out), 32'h0);
      clean();
   endtask

   task automatic t_level_low();
      set_pin(14, 1'b0);
      set_style(14, 3'd1);
      cyc(4);
      chk("R3", "low level code 1 sets", 32'(irq_out), 32'h0000_4000);
      wr(2'd2, 32'h0000_4000);
      chk("R8", "low level clear refused", 32'(irq_out), 32'h0000_4000);
      set_pin(14, 1'b1);
      cyc(4);
      wr(2'd2, 32'h0000_4000);
      chk("R8", "low level clear after release", 32'(irq_out), 32'h0);
      set_style(14, 3'd6);
      clean();
   endtask

   task automatic t_disabled();
      set_style(7, 3'd5);
      set_style(10, 3'd7);
      set_style(1, 3'd6);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         pins[7] = ~pins[7]; pins[10] = ~pins[10]; pins[1] = ~pins[1];
         cyc(4);
      end
      chk("R3", "codes 5..7 never set", 32'(irq_out), 32'h0);
      clean();
   endtask

   task automatic t_style_change();
      set_style(4, 3'd5);
      set_pin(4, 1'b1);
      cyc(4);
      wr(2'd2, 32'h0000_FFFF);
      set_style(4, 3'd2);
      cyc(4);
      chk("R11", "switch to rising on stable pin", 32'(irq_out), 32'h0);
      set_style(4, 3'd4);
      cyc(4);
      chk("R11", "switch to any on stable pin", 32'(irq_out), 32'h0);
      set_style(4, 3'd3);
      cyc(4);
      chk("R11", "switch to falling on stable pin", 32'(irq_out), 32'h0);
      clean();
   endtask

   initial begin
      shadow[0] = '0; shadow[1] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_style_rw();
      t_rise();
      t_fall();
      t_any();
      t_level_high();
      t_level_low();
      t_disabled();
      t_style_change();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule